// File: doc/BRIEF.md
# TDM Switch Host Access Port

This block gives a host processor access to the memories of a time-division-multiplexed switch over a simple non-multiplexed parallel bus. The host drives a chip select, a data strobe, a read/write line, six address lines and an 8-bit write bus; the block answers with read data and an acknowledge. One location in the lower address half is an 8-bit control register. It chooses the memory that the upper address half opens onto: connection memory low, connection memory high or data memory. It also chooses which stream's 32-channel page is visible. Two further control bits switch on split operation and message output.

The memories are shared with the switching datapath. That datapath writes received samples into data memory and reads both connection memories through its own port. The datapath owns every memory cycle of a channel time except the last one, which is the spare cycle handed to the host. A host memory access therefore waits for that spare cycle, and the acknowledge delay depends on where in the channel time the request lands. Control register accesses need no memory cycle and are acknowledged at once.

Top module: `tdm_host_port`

## Requirements
- R1: An access with addr[5]=0 and addr[1:0]=00 reaches the control register, whatever addr[4:2] hold. A write stores the data with bit 5 forced to 0, a read returns the stored value, and the acknowledge rises on the first clock edge after the request, with no slot wait.
- R2: Control bits [4:3] select the memory for windowed accesses: 00 is connection memory low, 01 is connection memory high and 10 is data memory. With 11, reads return 0 and writes change no memory. Control bits [2:0] select the stream page.
- R3: An access with addr[5]=1 reaches location stream*32 + addr[4:0] of the selected memory. Connection memory low and high return what the host wrote. The datapath read port shows both memories at its address one clock after that address is applied.
- R4: Data memory is read-only from the host. Host reads return what the datapath wrote, and host writes to it leave every memory unchanged.
- R5: When control bit 7 (split) is 1, host memory reads return data memory and host memory writes go to connection memory low, whatever the select field holds.
- R6: Control bit 6 (message enable) is driven on msg_en to the datapath.
- R7: A slot counter runs 0..SLOTS-1 from reset, and slot SLOTS-1 is the host's spare cycle. A memory access is performed only in that slot, and the acknowledge rises in the cycle after it, so the latency is between 1 and SLOTS cycles.
- R8: The acknowledge stays high while select and strobe are both held, and it falls one clock after either of them is released. Read data stays stable while the acknowledge is high, and a held request performs only one access.
- R9: An access with addr[5]=0 and addr[1:0] not 00 reads 0, writes nothing, and is acknowledged with no slot wait.
- R10: After reset the acknowledge, the read data, msg_en and the control register are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host chip select, active high |
| host_ds | input | 1 | Host data strobe, active high |
| host_rd | input | 1 | 1 = read, 0 = write |
| host_addr | input | 6 | Host address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid while host_ack is high |
| host_ack | output | 1 | Access acknowledge |
| msg_en | output | 1 | Message enable to the datapath |
| tdm_dm_we | input | 1 | Datapath data memory write enable |
| tdm_dm_addr | input | $clog2(STREAMS)+5 | Datapath data memory write address |
| tdm_dm_data | input | 8 | Datapath data memory write data |
| tdm_cm_addr | input | $clog2(STREAMS)+5 | Datapath connection memory read address |
| tdm_cml | output | 8 | Connection memory low at tdm_cm_addr, registered |
| tdm_cmh | output | 8 | Connection memory high at tdm_cm_addr, registered |

## Verification
The hardest situation to reach is a memory request arriving in each possible position of the channel time. The host has no view of the slot counter, so the cases differ only in how long the acknowledge takes. The bench keeps its own slot count from reset and varies the number of idle cycles before each memory access. Across the sweeps, requests start in every slot, and each acknowledge is checked to follow the spare cycle within SLOTS cycles. Split mode with the select field pointing at connection memory high is the other hard case: the bench checks that writes land in connection memory low through the datapath port, which the host cannot see at that moment.

// File: rtl/tdm_host_port.sv
`timescale 1ns/1ps
module tdm_host_port #(
  parameter int STREAMS = 8,
  parameter int SLOTS   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_cs,
  input  logic                          host_ds,
  input  logic                          host_rd,
  input  logic [5:0]                    host_addr,
  input  logic [7:0]                    host_wdata,
  output logic [7:0]                    host_rdata,
  output logic                          host_ack,
  output logic                          msg_en,
  input  logic                          tdm_dm_we,
  input  logic [$clog2(STREAMS)+4:0]    tdm_dm_addr,
  input  logic [7:0]                    tdm_dm_data,
  input  logic [$clog2(STREAMS)+4:0]    tdm_cm_addr,
  output logic [7:0]                    tdm_cml,
  output logic [7:0]                    tdm_cmh
);
  localparam int ST_W  = $clog2(STREAMS);
  localparam int IDX_W = ST_W + 5;
  localparam int DEPTH = STREAMS * 32;
  localparam int PH_W  = $clog2(SLOTS);
  localparam logic [1:0] SEL_CML = 2'b00;
  localparam logic [1:0] SEL_CMH = 2'b01;
  localparam logic [1:0] SEL_DM  = 2'b10;

  logic [7:0] cml_mem [DEPTH];
  logic [7:0] cmh_mem [DEPTH];
  logic [7:0] dm_mem  [DEPTH];

  logic [PH_W-1:0] phase_q;
  logic [7:0]      ctrl_q;
  logic            done_q;
  logic [7:0]      rdata_q;
  logic [7:0]      rd_val;

  logic             req, ctrl_hit, mem_hit, spare, split, start, mem_go, fin;
  logic             wr_cml, wr_cmh;
  logic [1:0]       msel;
  logic [IDX_W-1:0] idx;

  assign req      = host_cs & host_ds;
  assign ctrl_hit = !host_addr[5] && (host_addr[1:0] == 2'b00);
  assign mem_hit  = host_addr[5];
  assign spare    = (phase_q == PH_W'(SLOTS - 1));
  assign split    = ctrl_q[7];
  assign msel     = ctrl_q[4:3];
  assign idx      = {ctrl_q[ST_W-1:0], host_addr[4:0]};
  assign start    = req && !done_q;
  assign mem_go   = start && mem_hit && spare;
  assign fin      = start && (!mem_hit || spare);
  assign wr_cml   = mem_go && !host_rd && (split || msel == SEL_CML);
  assign wr_cmh   = mem_go && !host_rd && !split && msel == SEL_CMH;

  assign host_ack   = done_q;
  assign host_rdata = rdata_q;
  assign msg_en     = ctrl_q[6];

  always_comb begin
    rd_val = '0;
    if (ctrl_hit)
      rd_val = ctrl_q;
    else if (mem_hit) begin
      if (split || msel == SEL_DM) rd_val = dm_mem[idx];
      else if (msel == SEL_CML)    rd_val = cml_mem[idx];
      else if (msel == SEL_CMH)    rd_val = cmh_mem[idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= spare ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (start && ctrl_hit && !host_rd) ctrl_q <= host_wdata & 8'hDF;
      if (!req)     done_q <= 1'b0;
      else if (fin) done_q <= 1'b1;
      if (fin && host_rd) rdata_q <= rd_val;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_cml)    cml_mem[idx] <= host_wdata;
    if (wr_cmh)    cmh_mem[idx] <= host_wdata;
    if (tdm_dm_we) dm_mem[tdm_dm_addr] <= tdm_dm_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdm_cml <= '0;
      tdm_cmh <= '0;
    end else begin
      tdm_cml <= cml_mem[tdm_cm_addr];
      tdm_cmh <= cmh_mem[tdm_cm_addr];
    end
  end

  // R7
  spare_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !done_q && mem_hit && !spare) |=> !host_ack);
  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !host_ack);
  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> (!host_ack || $stable(host_rdata)));
  // R8
  ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ack) |-> $past(req));
  // R1
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && ctrl_hit && !host_rd) |=> $stable(ctrl_q));
  // R9
  unmapped_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mem_hit) |=> host_ack);
endmodule

// File: tb/test_tdm_host_port.sv
`timescale 1ns/1ps
module test_tdm_host_port;
  localparam int S = 4;
  localparam int NS = 8;

  logic clk = 0, rst_n = 0;
  logic host_cs = 0, host_ds = 0, host_rd = 0;
  logic [5:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic host_ack, msg_en;
  logic tdm_dm_we = 0;
  logic [7:0] tdm_dm_addr = 0, tdm_cm_addr = 0, tdm_dm_data = 0;
  logic [7:0] tdm_cml, tdm_cmh;

  int checks = 0, fails = 0;
  int ph = 0;
  bit rel_cs = 0;

  tdm_host_port #(.STREAMS(NS), .SLOTS(S)) i_tdm_host_port (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_ds(host_ds), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ack(host_ack), .msg_en(msg_en), .tdm_dm_we(tdm_dm_we), .tdm_dm_addr(tdm_dm_addr),
    .tdm_dm_data(tdm_dm_data), .tdm_cm_addr(tdm_cm_addr), .tdm_cml(tdm_cml), .tdm_cmh(tdm_cmh));

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ph <= 0;
    else        ph <= (ph == S - 1) ? 0 : ph + 1;

  function automatic logic [7:0] pf(int s, int c); return 8'(s * 37 + c * 5 + 1); endfunction
  function automatic logic [7:0] pg(int s, int c); return ~pf(s, c); endfunction
  function automatic logic [7:0] ph_dm(int s, int c); return 8'(s * 11 + c * 3) ^ 8'h5A; endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic acc(input bit rd, input logic [5:0] a, input logic [7:0] wd,
                     input int hold, output logic [7:0] q);
    int n = 0;
    host_cs = 1; host_ds = 1; host_rd = rd; host_addr = a; host_wdata = wd;
    do begin @(negedge clk); n++; end while (!host_ack && n < 3 * S + 4);
    if (a[5]) begin
      chk(ph == 0, "R7 grant in spare slot", ph, 0);
      chk(n <= S, "R7 latency", n, S);
    end else
      chk(n == 1, "R1 R9 immediate ack", n, 1);
    q = host_rdata;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(host_ack && host_rdata == q, "R8 hold", host_rdata, q);
    end
    if (rel_cs) host_cs = 0; else host_ds = 0;
    rel_cs = !rel_cs;
    @(negedge clk);
    chk(!host_ack, "R8 release", host_ack, 0);
    host_cs = 0; host_ds = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] q;
    acc(0, a, d, 0, q);
  endtask

  task automatic rdc(input logic [5:0] a, input logic [7:0] e, input string r, input int hold = 0);
    logic [7:0] q;
    acc(1, a, 8'h00, hold, q);
    chk(q == e, r, q, e);
  endtask

  task automatic port_chk(input int s, input int c, input logic [7:0] el, input logic [7:0] eh, input string r);
    tdm_cm_addr = 8'(s * 32 + c);
    @(negedge clk);
    chk(tdm_cml == el, r, tdm_cml, el);
    chk(tdm_cmh == eh, r, tdm_cmh, eh);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] k;
    repeat (3) @(negedge clk);
    // R10
    chk(!host_ack, "R10 ack", host_ack, 0);
    chk(host_rdata == 0, "R10 rdata", host_rdata, 0);
    chk(!msg_en, "R10 msg_en", msg_en, 0);
    rst_n = 1;
    @(negedge clk);
    rdc(6'h00, 8'h00, "R10 control reset");

    // R1 R6 control register sweep with aliases on addr[4:2]
    for (int v = 0; v < 256; v++) begin
      logic [5:0] a;
      a = {1'b0, 3'(v), 2'b00};
      wr(a, 8'(v));
      chk(msg_en == v[6], "R6 msg_en", msg_en, v[6]);
      rdc(6'(a ^ 6'h1C), 8'(v) & 8'hDF, "R1 control readback", v % 3);
    end

    // R9 unmapped lower addresses
    wr(6'h00, 8'h1A);
    for (int a = 1; a < 32; a++) begin
      if (a % 4 == 0) continue;
      wr(6'(a), 8'hFF);
      rdc(6'(a), 8'h00, "R9 unmapped read");
    end
    rdc(6'h00, 8'h1A, "R9 control untouched");

    // R3 fill CML and CMH
    for (int s = 0; s < NS; s++) begin
      wr(6'h00, 8'(s));
      for (int c = 0; c < 32; c++) begin
        repeat (c % S) @(negedge clk);
        wr({1'b1, 5'(c)}, pf(s, c));
      end
      wr(6'h00, 8'(8'h08 | s));
      for (int c = 0; c < 32; c++) begin
        repeat ((c + 1) % S) @(negedge clk);
        wr({1'b1, 5'(c)}, pg(s, c));
      end
    end
    for (int s = 0; s < NS; s++) begin
      wr(6'h00, 8'(s));
      for (int c = 0; c < 32; c++) rdc({1'b1, 5'(c)}, pf(s, c), "R3 CML readback", c % 2);
      wr(6'h00, 8'(8'h08 | s));
      for (int c = 0; c < 32; c++) rdc({1'b1, 5'(c)}, pg(s, c), "R3 CMH readback");
      for (int c = 0; c < 32; c += 5) port_chk(s, c, pf(s, c), pg(s, c), "R3 datapath port");
    end

    // R4 data memory filled by datapath, read-only to host
    for (int i = 0; i < NS * 32; i++) begin
      tdm_dm_we = 1; tdm_dm_addr = 8'(i); tdm_dm_data = ph_dm(i / 32, i % 32);
      @(negedge clk);
    end
    tdm_dm_we = 0;
    for (int s = 0; s < NS; s++) begin
      wr(6'h00, 8'(8'h10 | s));
      for (int c = 0; c < 32; c += 3) begin
        rdc({1'b1, 5'(c)}, ph_dm(s, c), "R4 DM read");
        wr({1'b1, 5'(c)}, ~ph_dm(s, c));
        rdc({1'b1, 5'(c)}, ph_dm(s, c), "R4 DM write ignored");
        port_chk(s, c, pf(s, c), pg(s, c), "R4 CM untouched");
      end
    end

    // R2 select 11: no memory
    for (int s = 0; s < NS; s += 3) begin
      wr(6'h00, 8'(8'h18 | s));
      for (int c = 0; c < 32; c += 7) begin
        rdc({1'b1, 5'(c)}, 8'h00, "R2 select 11 read");
        wr({1'b1, 5'(c)}, 8'hEE);
        port_chk(s, c, pf(s, c), pg(s, c), "R2 select 11 write dropped");
      end
    end

    // R5 split mode with select pointing at CMH
    for (int s = 0; s < NS; s++) begin
      wr(6'h00, 8'(8'h88 | s));
      for (int c = 0; c < 32; c += 4) begin
        k = 8'(c) ^ 8'h33 ^ 8'(s);
        rdc({1'b1, 5'(c)}, ph_dm(s, c), "R5 split read from DM", 1);
        wr({1'b1, 5'(c)}, k);
        port_chk(s, c, k, pg(s, c), "R5 split write to CML");
      end
      wr(6'h00, 8'(s));
      for (int c = 0; c < 32; c += 4) begin
        k = 8'(c) ^ 8'h33 ^ 8'(s);
        rdc({1'b1, 5'(c)}, k, "R5 CML after split");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule